// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the station side of a two-wire PHY management link. A host places a single-cycle request carrying a read/write select, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block then serializes a complete clause-22 style frame onto the MDC clock and MDIO data pins. For reads it returns the captured 16-bit register value together with a one-cycle completion pulse. MDC is generated from the system clock by a divider whose half-period is `DIV+1` system clocks. The MDIO output enable is controlled bit by bit, so the line can be released for turnaround and idle.

While no frame is running, the pins are driven from a small direct-control register. Software can use it to toggle the pins by hand. Its read side shows the pin values and a synchronized copy of the MDIO input.

Top module: `mdio_master`

## Requirements
- R1: A frame starts with 32 driven ones, then the start bits 01, then the opcode (10 = read, 01 = write), then the PHY address and then the register address. Each field is sent MSB first.
- R2: Every bit period is an MDC low half followed by an MDC high half, each lasting exactly DIV+1 system clocks. MDC is low whenever no frame is in progress and the direct-control register holds MDC at 0.
- R3: In a write frame, the address field is followed by the turnaround bits 10 and then the 16 data bits MSB first, all driven. Next comes one bit period with MDIO released and MDC held low, after which done is raised. A write frame lasts 65 bit periods in total.
- R4: In a read frame, MDIO is released after the register address for one MDC cycle. Then 16 bits are shifted in MSB first, each sampled on the last system clock of the MDC high half. A read frame lasts 63 bit periods, of which the first 46 are driven.
- R5: done is high for exactly one system clock at the end of each frame. For a read, rdata holds the captured value in that same cycle and afterwards.
- R6: busy rises on the cycle after an accepted request (req with busy low) and falls with done. A req while busy is ignored and does not change the frame in progress.
- R7: The direct-control register has bit 0 = MDC, bit 1 = output enable (1 = drive) and bit 2 = output value. bb_rdata[3] shows MDIO input one clock late. When not busy, the pins follow register bits 2:0.
- R8: A direct-control write while busy is ignored and leaves the register unchanged.
- R9: After reset, busy, done, mdc, mdio_oe and mdio_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a frame (accepted when busy is low) |
| rd_nwr | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | Register address |
| wdata | input | 16 | Data for a write frame |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rdata | output | 16 | Data captured by the last read |
| bb_we | input | 1 | Write the direct-control register |
| bb_wdata | input | 3 | New direct-control value {data, enable, clock} |
| bb_rdata | output | 4 | {synced MDIO in, data, enable, clock} |
| mdc | output | 1 | Management clock pin |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench builds the block with DIV = 1, so each bit period is four system clocks. This keeps full 63- and 65-bit frames short enough to run several back to back, and it still leaves a high half longer than one clock, which makes an off-by-one in the half-period measurable. A bus-functional PHY model watches MDC edges to rebuild the driven bits and the release pattern. It answers reads on the released line. Exact frame lengths in system clocks follow from DIV.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 16;
  localparam int PRE_LEN = 32;
  // header: preamble + start + opcode + two addresses
  localparam int HDR_BITS = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int WR_BITS  = HDR_BITS + 2 + DATA_W;
  localparam int RD_BITS  = HDR_BITS + 1 + DATA_W;
  localparam int FRM_W    = WR_BITS;
  localparam logic [1:0] START_PAT = 2'b01;
  localparam logic [1:0] OP_RD     = 2'b10;
  localparam logic [1:0] OP_WR     = 2'b01;
  localparam logic [1:0] TA_WR     = 2'b10;
endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
  parameter int DIV_W = 8,
  parameter int DIV   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic half_end
);
  localparam logic [DIV_W-1:0] LIMIT = DIV_W'(DIV);
  logic [DIV_W-1:0] cnt;

  assign half_end = en && (cnt == LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= half_end ? '0 : cnt + 1'b1;
  end

  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              rd_nwr,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              half_end,
  input  logic              mdio_i,
  output logic              start,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              mdc_r,
  output logic              oe_r,
  output logic              do_r
);
  localparam int IDX_W = $clog2(WR_BITS + 2);
  localparam logic [IDX_W-1:0] HDR_I  = IDX_W'(HDR_BITS);
  localparam logic [IDX_W-1:0] WR_I   = IDX_W'(WR_BITS);
  localparam logic [IDX_W-1:0] RDL_I  = IDX_W'(RD_BITS - 1);
  localparam logic [IDX_W-1:0] SMP0_I = IDX_W'(HDR_BITS + 1);

  logic [FRM_W-1:0] sreg, frame;
  logic [IDX_W-1:0] idx, idx_nxt;
  logic             is_rd, phase;
  logic             idle_bit, sample, last_bit, drive_nxt;

  assign frame = {{PRE_LEN{1'b1}}, START_PAT, (rd_nwr ? OP_RD : OP_WR),
                  phy_addr, reg_addr, TA_WR, wdata};
  assign start    = req && !busy;
  assign idx_nxt  = idx + 1'b1;
  assign idle_bit = !is_rd && (idx == WR_I);
  assign sample   = is_rd && (idx >= SMP0_I);
  assign last_bit = is_rd ? (idx == RDL_I) : (idx == WR_I);
  assign drive_nxt = is_rd ? (idx_nxt < HDR_I) : (idx_nxt < WR_I);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; rdata <= '0; sreg <= '0; idx <= '0;
      is_rd <= 1'b0; phase <= 1'b0; mdc_r <= 1'b0; oe_r <= 1'b0; do_r <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        is_rd <= rd_nwr;
        sreg  <= frame;
        idx   <= '0;
        phase <= 1'b0;
        mdc_r <= 1'b0;
        oe_r  <= 1'b1;
        do_r  <= frame[FRM_W-1];
      end else if (busy && half_end) begin
        if (!phase) begin
          phase <= 1'b1;
          mdc_r <= !idle_bit;
        end else begin
          phase <= 1'b0;
          mdc_r <= 1'b0;
          if (sample) rdata <= {rdata[DATA_W-2:0], mdio_i};
          if (last_bit) begin
            busy <= 1'b0;
            done <= 1'b1;
            oe_r <= 1'b0;
            do_r <= 1'b0;
          end else begin
            idx  <= idx_nxt;
            sreg <= sreg << 1;
            do_r <= sreg[FRM_W-2];
            oe_r <= drive_nxt;
          end
        end
      end
    end
  end

  assert_mdc_edge_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (mdc_r != $past(mdc_r)) |-> $past(half_end));
  assert_mdc_low_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc_r);
  assert_rd_released_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && is_rd && idx >= HDR_I) |-> !oe_r);
  assert_wr_idle_released_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && idle_bit) |-> (!oe_r && !mdc_r));
  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_ends_busy_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/mdio_bitbang_reg.sv
module mdio_bitbang_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic       busy,
  input  logic [2:0] wdata,
  input  logic       mdio_i,
  output logic [2:0] q,
  output logic       din_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      din_q <= 1'b0;
    end else begin
      din_q <= mdio_i;
      if (we && !busy) q <= wdata;
    end
  end

  assert_bb_blocked_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && we) |=> $stable(q));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int DIV   = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic        rd_nwr,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  input  logic        bb_we,
  input  logic [2:0]  bb_wdata,
  output logic [3:0]  bb_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic       start, half_end;
  logic       s_mdc, s_oe, s_do;
  logic [2:0] bb_q;
  logic       bb_din;

  mdio_mdc_div #(.DIV_W(DIV_W), .DIV(DIV)) u_div (
    .clk(clk), .rst(rst), .clr(start), .en(busy), .half_end(half_end));

  mdio_frame_seq u_seq (
    .clk(clk), .rst(rst), .req(req), .rd_nwr(rd_nwr),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
    .half_end(half_end), .mdio_i(mdio_i), .start(start),
    .busy(busy), .done(done), .rdata(rdata),
    .mdc_r(s_mdc), .oe_r(s_oe), .do_r(s_do));

  mdio_bitbang_reg u_bb (
    .clk(clk), .rst(rst), .we(bb_we), .busy(busy), .wdata(bb_wdata),
    .mdio_i(mdio_i), .q(bb_q), .din_q(bb_din));

  assign mdc      = busy ? s_mdc : bb_q[0];
  assign mdio_oe  = busy ? s_oe  : bb_q[1];
  assign mdio_o   = busy ? s_do  : bb_q[2];
  assign bb_rdata = {bb_din, bb_q};

  assert_busy_from_req_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req));
  assert_busy_ignores_req_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && !half_end) |=> busy);
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 1;
  localparam int HALF = DIV + 1;

  logic        clk = 1'b0, rst = 1'b1;
  logic        req = 1'b0, rd_nwr = 1'b0;
  logic [4:0]  phy_addr = '0, reg_addr = '0;
  logic [15:0] wdata = '0;
  logic        busy, done;
  logic [15:0] rdata;
  logic        bb_we = 1'b0;
  logic [2:0]  bb_wdata = '0;
  logic [3:0]  bb_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        bb_mode = 1'b0, bb_in = 1'b0, phy_drv = 1'b0;

  int errors = 0, checks = 0, cycles = 0;

  // PHY model state
  int          rises = 0, driven = 0, hi_cnt = 0, hp_bad = 0;
  logic        mdc_prev = 1'b0, seen_rel = 1'b0, order_bad = 1'b0;
  logic [63:0] cap = '0;
  logic [15:0] rval = '0;

  assign mdio_i = bb_mode ? bb_in : phy_drv;

  mdio_master #(.DIV_W(8), .DIV(DIV)) dut (
    .clk(clk), .rst(rst), .req(req), .rd_nwr(rd_nwr), .phy_addr(phy_addr),
    .reg_addr(reg_addr), .wdata(wdata), .busy(busy), .done(done),
    .rdata(rdata), .bb_we(bb_we), .bb_wdata(bb_wdata), .bb_rdata(bb_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (mdc && !mdc_prev) begin
      rises++;
      if (mdio_oe) begin
        cap = {cap[62:0], mdio_o};
        driven++;
        if (seen_rel) order_bad = 1'b1;
      end else seen_rel = 1'b1;
      if (rises >= 48 && rises <= 63) phy_drv = rval[15 - (rises - 48)];
      hi_cnt = 1;
    end else if (mdc) hi_cnt++;
    if (!mdc && mdc_prev && !bb_mode && hi_cnt != HALF) hp_bad++;
    mdc_prev = mdc;
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mon_clear();
    rises = 0; driven = 0; hp_bad = 0; cap = '0;
    seen_rel = 1'b0; order_bad = 1'b0; phy_drv = 1'b0;
  endtask

  task automatic launch(input logic rd, input logic [4:0] pa,
                        input logic [4:0] ra, input logic [15:0] wd);
    @(negedge clk);
    req = 1'b1; rd_nwr = rd; phy_addr = pa; reg_addr = ra; wdata = wd;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    chk(!busy && !done, "R9 busy/done", {busy, done}, 0);
    chk(!mdc && !mdio_oe && !mdio_o, "R9 pins", {mdc, mdio_oe, mdio_o}, 0);
  endtask

  task automatic t_write(input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd);
    logic [63:0] exp;
    int n;
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, pa, ra, 2'b10, wd};
    mon_clear();
    launch(1'b0, pa, ra, wd);
    chk(busy, "R6 busy after req", busy, 1);
    wait_done(n);
    chk(cap == exp, "R1 R3 write bits", cap, exp);
    chk(driven == 64 && rises == 64, "R3 write driven/rises", driven, 64);
    chk(n == 65 * 2 * HALF, "R3 write length", n, 65 * 2 * HALF);
    chk(hp_bad == 0, "R2 high half length", hp_bad, 0);
    @(negedge clk);
    chk(!done && !busy, "R5 done one cycle", done, 0);
    chk(!mdc && !mdio_oe, "R2 idle pins", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_read(input logic [4:0] pa, input logic [4:0] ra,
                        input logic [15:0] val);
    logic [45:0] exp;
    int n;
    exp = {32'hFFFF_FFFF, 2'b01, 2'b10, pa, ra};
    mon_clear();
    rval = val;
    launch(1'b1, pa, ra, 16'hDEAD);
    wait_done(n);
    chk(done && rdata == val, "R4 R5 rdata with done", rdata, val);
    chk(cap[45:0] == exp, "R1 read header", cap[45:0], exp);
    chk(driven == 46 && rises == 63 && !order_bad, "R4 release pattern",
        driven, 46);
    chk(n == 63 * 2 * HALF, "R4 read length", n, 63 * 2 * HALF);
    chk(hp_bad == 0, "R2 read high half", hp_bad, 0);
    @(negedge clk);
    chk(!done && rdata == val, "R5 done one cycle, rdata held", rdata, val);
  endtask

  task automatic t_busy_ignore();
    logic [63:0] exp;
    int n;
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h0C, 5'h13, 2'b10, 16'h5A3C};
    mon_clear();
    launch(1'b0, 5'h0C, 5'h13, 16'h5A3C);
    repeat (30) @(negedge clk);
    req = 1'b1; rd_nwr = 1'b1; phy_addr = 5'h1F; reg_addr = 5'h00;
    wdata = 16'hFFFF;
    @(negedge clk);
    req = 1'b0;
    wait_done(n);
    chk(cap == exp && rises == 64, "R6 frame unchanged by req", cap, exp);
    repeat (3) @(negedge clk);
    chk(!busy, "R6 ignored req not queued", busy, 0);
  endtask

  task automatic t_bitbang();
    bb_mode = 1'b1;
    @(negedge clk); bb_we = 1'b1; bb_wdata = 3'b111;
    @(negedge clk); bb_we = 1'b0;
    chk({mdio_o, mdio_oe, mdc} == 3'b111, "R7 pins follow reg",
        {mdio_o, mdio_oe, mdc}, 3'b111);
    chk(bb_rdata[2:0] == 3'b111, "R7 reg readback", bb_rdata, 4'b0111);
    bb_in = 1'b1;
    @(negedge clk);
    chk(bb_rdata[3] == 1'b1, "R7 input bit 3", bb_rdata, 4'b1111);
    bb_in = 1'b0;
    @(negedge clk); bb_we = 1'b1; bb_wdata = 3'b010;
    @(negedge clk); bb_we = 1'b0;
    chk({mdio_o, mdio_oe, mdc} == 3'b010 && bb_rdata == 4'b0010,
        "R7 second pattern", bb_rdata, 4'b0010);
    @(negedge clk); bb_we = 1'b1; bb_wdata = 3'b000;
    @(negedge clk); bb_we = 1'b0;
    bb_mode = 1'b0;
  endtask

  task automatic t_bb_blocked();
    int n;
    mon_clear();
    launch(1'b0, 5'h01, 5'h02, 16'h0003);
    repeat (10) @(negedge clk);
    bb_we = 1'b1; bb_wdata = 3'b101;
    @(negedge clk);
    bb_we = 1'b0;
    wait_done(n);
    @(negedge clk);
    chk(bb_rdata[2:0] == 3'b000, "R8 write while busy ignored",
        bb_rdata[2:0], 3'b000);
    chk({mdio_o, mdio_oe, mdc} == 3'b000, "R8 pins after frame",
        {mdio_o, mdio_oe, mdc}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write(5'h11, 5'h05, 16'hA5C3);
    t_write(5'h00, 5'h1F, 16'h0001);
    t_read(5'h07, 5'h01, 16'h8001);
    t_read(5'h1A, 5'h10, 16'h3C5A);
    t_busy_ignore();
    t_bitbang();
    t_bb_blocked();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule